// File: doc/BRIEF.md
# Region Pointer Translation Unit

This block translates in both directions between a compact 64-bit region pointer and an absolute 64-bit virtual address inside a persistent-memory region. A region pointer packs a 32-bit region number above a 32-bit byte offset. Persistent regions live in the top of the address space: a run of leading one bits, then a segment number, then the byte position inside that segment. Every region begins on a segment boundary.

Two direct-indexed tables of 8-byte entries sit at fixed high addresses. One is indexed by segment number and holds region numbers. The other is indexed by region number and holds segment base addresses. Both base addresses come from the three configured field widths. They are derived once, when the widths are written, and then kept in registers. A translation therefore costs some field arithmetic and exactly one memory read. Malformed inputs are rejected before any read is issued.

Requests arrive on a valid/ready handshake. The unit holds at most one memory read in flight and answers in request order with a one-cycle response pulse.

Top module: `rpx_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0. The reset widths are 16 leading ones, a 12-bit segment field and an 8-bit region-index field.
- R2: With `req_dir`=0, pointer to address, `req_data[63:32]` is the region number and `req_data[31:0]` is the offset. The read address is B1 + 8·region. B1 is the leading-ones prefix with bit (max(seg width, region width)+3) also set. The response is the returned entry plus the offset.
- R3: With `req_dir`=1, address to pointer, the read address is B0 + 8·segment. B0 is the leading-ones prefix followed by zeros. The response is {entry[31:0], in-segment offset}.
- R4: A region number with any bit set at or above the region-index width gives an error response with data 0 and issues no memory read.
- R5: An address to pointer request whose leading bits are not all ones, or whose in-segment offset does not fit in 32 bits, gives an error response with data 0 and issues no memory read.
- R6: A returned table entry of zero gives an error response with data 0, in either direction.
- R7: Every accepted request that passes the input checks issues exactly one `mem_req` pulse, one cycle long, in the cycle after acceptance. `req_ready` stays low from acceptance until the response.
- R8: `rsp_valid` pulses for one cycle. The pulse comes one cycle after `mem_rvalid` for a request that read memory, or one cycle after acceptance for a rejected request. Responses stay in request order.
- R9: A write on `cfg_we` while idle with consistent widths sets new leading-ones, segment and region-index widths for the requests that follow. Consistent means: each width is at least 1, the region width is at most the maximum, leading+segment ≤ 63, and leading + max(segment, region) + 3 ≤ 63.
- R10: A width write that is inconsistent, or that arrives while a read is outstanding, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_dir | input | 1 | 0: pointer to address, 1: address to pointer |
| req_data | input | 64 | Pointer or address to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 64 | Translated value, 0 on error |
| mem_req | output | 1 | Table read pulse |
| mem_addr | output | 64 | Table entry address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Table entry |
| cfg_we | input | 1 | Width write strobe |
| cfg_lead | input | 6 | Leading-ones width |
| cfg_seg | input | 6 | Segment field width |
| cfg_rid | input | 6 | Region-index width |

## Verification
The bench builds the unit with its default reset widths of 16 leading ones, a 12-bit segment field and an 8-bit region index. That leaves a 36-bit in-segment field, so an address whose offset spills past 32 bits can be produced. With the segment field wider than the region index, the segment width picks the second-table bit. The bench then rewrites the widths to 20/12/14, where the region index is wider and a 32-bit in-segment field results. This reaches the other choice of table bit and shows that the derived bases follow the new widths.

// File: rtl/rpx_pkg.sv
package rpx_pkg;
   localparam int AW = 64;
   localparam int CW = 6;
   localparam int ENT_SHIFT = 3;

   typedef enum logic {DIR_TO_VA = 1'b0, DIR_TO_PTR = 1'b1} xdir_e;
   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} xst_e;

   typedef struct packed {
      logic [AW-1:0] lead_mask;
      logic [AW-1:0] seg_tab;
      logic [AW-1:0] rid_tab;
      logic [CW-1:0] l2;
      logic [CW-1:0] l3;
      logic [CW-1:0] l4;
   } xcfg_t;

   function automatic logic cfg_ok(input logic [CW-1:0] l1, input logic [CW-1:0] l2,
                                   input logic [CW-1:0] l4, input logic [CW-1:0] max_l4);
      logic [7:0] a, b, c, big;
      a = 8'(l1);
      b = 8'(l2);
      c = 8'(l4);
      big = (b > c) ? b : c;
      return (a != 0) && (b != 0) && (c != 0) && (l4 <= max_l4) &&
             ((a + b) <= 8'd63) && ((a + big + 8'd3) <= 8'd63);
   endfunction

   function automatic xcfg_t cfg_derive(input logic [CW-1:0] l1, input logic [CW-1:0] l2,
                                        input logic [CW-1:0] l4);
      xcfg_t r;
      logic [7:0] big;
      big = (l2 > l4) ? 8'(l2) : 8'(l4);
      r.lead_mask = ~64'd0 << (8'd64 - 8'(l1));
      r.seg_tab   = r.lead_mask;
      r.rid_tab   = r.lead_mask | (64'd1 << (big + 8'(ENT_SHIFT)));
      r.l2        = l2;
      r.l3        = CW'(8'd64 - 8'(l1) - 8'(l2));
      r.l4        = l4;
      return r;
   endfunction
endpackage

// File: rtl/rpx_cfg.sv
module rpx_cfg
   import rpx_pkg::*;
#(
   parameter int DEF_L1 = 16,
   parameter int DEF_L2 = 12,
   parameter int DEF_L4 = 8,
   parameter int MAX_L4 = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          busy,
   input  logic          we,
   input  logic [CW-1:0] l1,
   input  logic [CW-1:0] l2,
   input  logic [CW-1:0] l4,
   output xcfg_t         cfg
);
   localparam logic [CW-1:0] D1 = CW'(DEF_L1);
   localparam logic [CW-1:0] D2 = CW'(DEF_L2);
   localparam logic [CW-1:0] D4 = CW'(DEF_L4);
   localparam logic [CW-1:0] MX = CW'(MAX_L4);

   if (MAX_L4 < 1 || MAX_L4 > 32) begin : g_bad_max
      $error("rpx_cfg: MAX_L4 must lie in 1..32");
   end
   if (!cfg_ok(D1, D2, D4, MX)) begin : g_bad_def
      $error("rpx_cfg: default widths are inconsistent");
   end

   logic take;
   assign take = we && !busy && cfg_ok(l1, l2, l4, MX);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= cfg_derive(D1, D2, D4);
      end else if (take) begin
         cfg <= cfg_derive(l1, l2, l4);
      end
   end
endmodule

// File: rtl/rpx_addr.sv
module rpx_addr
   import rpx_pkg::*;
(
   input  xcfg_t         cfg,
   input  logic          dir,
   input  logic [AW-1:0] data,
   output logic          pre_err,
   output logic [AW-1:0] tab_addr,
   output logic [AW-1:0] keep
);
   logic [AW-1:0] rid, off_mask, seg_mask, off, seg;

   always_comb begin
      rid      = {32'd0, data[63:32]};
      off_mask = (64'd1 << cfg.l3) - 64'd1;
      seg_mask = (64'd1 << cfg.l2) - 64'd1;
      off      = data & off_mask;
      seg      = (data >> cfg.l3) & seg_mask;
      if (dir == DIR_TO_VA) begin
         pre_err  = (rid >> cfg.l4) != 64'd0;
         tab_addr = cfg.rid_tab + (rid << ENT_SHIFT);
         keep     = {32'd0, data[31:0]};
      end else begin
         pre_err  = ((data & cfg.lead_mask) != cfg.lead_mask) || (off[63:32] != 32'd0);
         tab_addr = cfg.seg_tab + (seg << ENT_SHIFT);
         keep     = off;
      end
   end
endmodule

// File: rtl/rpx_pack.sv
module rpx_pack
   import rpx_pkg::*;
(
   input  logic          dir,
   input  logic [AW-1:0] entry,
   input  logic [AW-1:0] keep,
   output logic          err,
   output logic [AW-1:0] res
);
   always_comb begin
      err = (entry == 64'd0);
      if (err)                   res = 64'd0;
      else if (dir == DIR_TO_VA) res = entry + keep;
      else                       res = {entry[31:0], keep[31:0]};
   end
endmodule

// File: rtl/rpx_xlate.sv
module rpx_xlate
   import rpx_pkg::*;
#(
   parameter int DEF_L1 = 16,
   parameter int DEF_L2 = 12,
   parameter int DEF_L4 = 8,
   parameter int MAX_L4 = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_dir,
   input  logic [63:0]   req_data,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [63:0]   rsp_data,
   output logic          mem_req,
   output logic [63:0]   mem_addr,
   input  logic          mem_rvalid,
   input  logic [63:0]   mem_rdata,
   input  logic          cfg_we,
   input  logic [5:0]    cfg_lead,
   input  logic [5:0]    cfg_seg,
   input  logic [5:0]    cfg_rid
);
   xst_e          st;
   xcfg_t         cfg;
   logic          pre_err, pk_err, dir_q;
   logic [AW-1:0] tab_addr, keep, keep_q, pk_res;

   assign req_ready = (st == ST_IDLE);

   rpx_cfg #(.DEF_L1(DEF_L1), .DEF_L2(DEF_L2), .DEF_L4(DEF_L4), .MAX_L4(MAX_L4)) u_cfg (
      .clk(clk), .rst(rst), .busy(st == ST_WAIT), .we(cfg_we),
      .l1(cfg_lead), .l2(cfg_seg), .l4(cfg_rid), .cfg(cfg)
   );

   rpx_addr u_addr (
      .cfg(cfg), .dir(req_dir), .data(req_data),
      .pre_err(pre_err), .tab_addr(tab_addr), .keep(keep)
   );

   rpx_pack u_pack (
      .dir(dir_q), .entry(mem_rdata), .keep(keep_q), .err(pk_err), .res(pk_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         dir_q     <= 1'b0;
         keep_q    <= '0;
      end else begin
         mem_req   <= 1'b0;
         rsp_valid <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               if (pre_err) begin
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_data  <= '0;
               end else begin
                  mem_req  <= 1'b1;
                  mem_addr <= tab_addr;
                  dir_q    <= req_dir;
                  keep_q   <= keep;
                  st       <= ST_WAIT;
               end
            end
            ST_WAIT: if (mem_rvalid) begin
               rsp_valid <= 1'b1;
               rsp_err   <= pk_err;
               rsp_data  <= pk_res;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rpx_xlate_chk.sv
module rpx_xlate_chk (
   input logic        clk,
   input logic        rst,
   input logic        req_valid,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [63:0] rsp_data,
   input logic        mem_req,
   input logic        mem_rvalid
);
   a_r7_mem_pulse: assert property (@(posedge clk) disable iff (rst)
      mem_req |=> !mem_req);
   a_r7_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !req_ready);
   a_r7_read_follows_accept: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> $past(req_valid && req_ready));
   a_r8_rsp_after_data: assert property (@(posedge clk) disable iff (rst)
      (mem_rvalid && !req_ready) |=> (rsp_valid && req_ready));
   a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !$past(req_valid && req_ready)) |=> !rsp_valid);
   a_r6_err_zero_data: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_err) |-> (rsp_data == 64'd0));
endmodule

bind rpx_xlate rpx_xlate_chk u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
   .mem_req(mem_req), .mem_rvalid(mem_rvalid)
);

// File: tb/rpx_xlate_tb.sv
`timescale 1ns/1ps
module rpx_xlate_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_dir = 1'b0;
   logic [63:0] req_data = '0;
   logic        req_ready, rsp_valid, rsp_err, mem_req;
   logic [63:0] rsp_data, mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_lead = '0, cfg_seg = '0, cfg_rid = '0;
   int          n_chk = 0, n_err = 0, n_reads = 0;

   always #10 clk = ~clk;

   rpx_xlate u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_dir(req_dir), .req_data(req_data), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_data(rsp_data), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .cfg_we(cfg_we), .cfg_lead(cfg_lead), .cfg_seg(cfg_seg), .cfg_rid(cfg_rid)
   );

   always @(posedge clk) if (!rst && mem_req) n_reads <= n_reads + 1;

   task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [5:0] a, input logic [5:0] b, input logic [5:0] c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lead = a; cfg_seg = b; cfg_rid = c;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // one translation; expects a table read at addr_x or an early rejection
   task automatic xlate(input logic dir, input logic [63:0] d, input logic rd_x,
                        input logic [63:0] addr_x, input logic [63:0] entry,
                        input logic err_x, input logic [63:0] res_x, input string tag);
      int r0;
      @(negedge clk);
      chk(req_ready, {tag, " ready before request"}, 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_dir = dir; req_data = d;
      r0 = n_reads;
      @(negedge clk);
      req_valid = 1'b0;
      if (rd_x) begin
         chk(mem_req && mem_addr == addr_x, {tag, " read address"}, mem_addr, addr_x);
         chk(!req_ready && !rsp_valid, {tag, " busy while reading"}, 64'(req_ready), 64'd0);
         @(negedge clk);
         chk(!mem_req, "R7 read pulse one cycle", 64'(mem_req), 64'd0);
         @(negedge clk);
         mem_rvalid = 1'b1; mem_rdata = entry;
         @(negedge clk);
         mem_rvalid = 1'b0;
         chk(rsp_valid && rsp_err == err_x && rsp_data == res_x, {tag, " response"},
             rsp_data, res_x);
         chk(n_reads == r0 + 1, "R7 exactly one read", 64'(n_reads - r0), 64'd1);
      end else begin
         chk(rsp_valid && rsp_err && rsp_data == 64'd0 && !mem_req, {tag, " rejected"},
             {rsp_data[62:0], rsp_err}, 64'd1);
      end
      @(negedge clk);
      chk(!rsp_valid, "R8 response pulse one cycle", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk(req_ready && !rsp_valid && !mem_req, "R1 reset state",
          {61'd0, req_ready, rsp_valid, mem_req}, 64'd4);
   endtask

   task automatic t_forward();
      xlate(1'b0, 64'h0000_0005_0000_1234, 1'b1, 64'hFFFF_0000_0000_8028,
            64'hFFFF_0030_0000_0000, 1'b0, 64'hFFFF_0030_0000_1234, "R2 fwd rid5");
      xlate(1'b0, 64'h0000_00FF_FFFF_FFFF, 1'b1, 64'hFFFF_0000_0000_87F8,
            64'hFFFF_FFF0_0000_0000, 1'b0, 64'hFFFF_FFF0_FFFF_FFFF, "R2 fwd top rid");
      xlate(1'b0, 64'h0000_0100_0000_0000, 1'b0, '0, '0, 1'b1, '0, "R4 rid too wide");
   endtask

   task automatic t_reverse();
      xlate(1'b1, 64'hFFFF_0030_0000_1234, 1'b1, 64'hFFFF_0000_0000_0018,
            64'h5, 1'b0, 64'h0000_0005_0000_1234, "R3 rev seg3");
      xlate(1'b1, 64'hFFFE_0030_0000_1234, 1'b0, '0, '0, 1'b1, '0, "R5 lead bits");
      xlate(1'b1, 64'hFFFF_0031_0000_0000, 1'b0, '0, '0, 1'b1, '0, "R5 offset wide");
   endtask

   task automatic t_unmapped();
      xlate(1'b0, 64'h0000_0007_0000_0010, 1'b1, 64'hFFFF_0000_0000_8038,
            64'd0, 1'b1, 64'd0, "R6 fwd zero entry");
      xlate(1'b1, 64'hFFFF_0050_0000_0040, 1'b1, 64'hFFFF_0000_0000_0028,
            64'd0, 1'b1, 64'd0, "R6 rev zero entry");
   endtask

   task automatic t_back_to_back();
      // two rejections on consecutive cycles, then a normal read
      @(negedge clk);
      req_valid = 1'b1; req_dir = 1'b0; req_data = 64'h0000_0200_0000_0000;
      @(negedge clk);
      chk(rsp_valid && rsp_err && req_ready, "R8 first rejection next cycle",
          64'(rsp_valid), 64'd1);
      req_dir = 1'b1; req_data = 64'h0000_0000_0000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid && rsp_err, "R8 second rejection next cycle", 64'(rsp_valid), 64'd1);
      xlate(1'b0, 64'h0000_0001_0000_0000, 1'b1, 64'hFFFF_0000_0000_8008,
            64'hFFFF_0010_0000_0000, 1'b0, 64'hFFFF_0010_0000_0000, "R8 after rejections");
   endtask

   task automatic t_cfg_busy();
      @(negedge clk);
      req_valid = 1'b1; req_dir = 1'b0; req_data = 64'h0000_0001_0000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b1; cfg_lead = 6'd20; cfg_seg = 6'd12; cfg_rid = 6'd14;
      @(negedge clk);
      cfg_we = 1'b0;
      mem_rvalid = 1'b1; mem_rdata = 64'hFFFF_0010_0000_0000;
      @(negedge clk);
      mem_rvalid = 1'b0;
      chk(rsp_valid && !rsp_err, "R10 busy run response", rsp_data, 64'hFFFF_0010_0000_0000);
      xlate(1'b0, 64'h0000_0002_0000_0000, 1'b1, 64'hFFFF_0000_0000_8010,
            64'hFFFF_0020_0000_0000, 1'b0, 64'hFFFF_0020_0000_0000, "R10 write while busy");
   endtask

   task automatic t_cfg_bad();
      write_cfg(6'd60, 6'd10, 6'd8);
      xlate(1'b0, 64'h0000_0002_0000_0000, 1'b1, 64'hFFFF_0000_0000_8010,
            64'hFFFF_0020_0000_0000, 1'b0, 64'hFFFF_0020_0000_0000, "R10 inconsistent widths");
      write_cfg(6'd16, 6'd12, 6'd20);
      xlate(1'b0, 64'h0000_0100_0000_0000, 1'b0, '0, '0, 1'b1, '0, "R10 region width over max");
   endtask

   task automatic t_cfg_new();
      write_cfg(6'd20, 6'd12, 6'd14);
      xlate(1'b0, 64'h0000_3FFF_0000_0004, 1'b1, 64'hFFFF_F000_0003_FFF8,
            64'hFFFF_F001_0000_0000, 1'b0, 64'hFFFF_F001_0000_0004, "R9 fwd new widths");
      xlate(1'b0, 64'h0000_4000_0000_0000, 1'b0, '0, '0, 1'b1, '0, "R9 new region limit");
      xlate(1'b1, 64'hFFFF_FABC_1234_5678, 1'b1, 64'hFFFF_F000_0000_55E0,
            64'h77, 1'b0, 64'h0000_0077_1234_5678, "R9 rev new widths");
      xlate(1'b1, 64'hFFFF_0ABC_1234_5678, 1'b0, '0, '0, 1'b1, '0, "R9 new lead width");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_forward();
      t_reverse();
      t_unmapped();
      t_back_to_back();
      t_cfg_busy();
      t_cfg_bad();
      t_cfg_new();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule